// File: doc/BRIEF.md
# Dual-Channel UART Interrupt Prioritizer

This block gathers every interrupt condition of a two-channel UART and turns them into one 3-bit source code per channel, a pending bit per channel, a global status word and a single interrupt line. Event strobes from the datapath set a sticky latch for each source. Each latch has its own clear event, usually a read of a particular register. A fixed-priority encoder then reports, for each channel, the pending source with the highest precedence.

The receive-ready condition is a level: the receive FIFO fill is at or above its trigger. It is not latched. The multipurpose I/O source and the timer source exist only on channel 0. The bus interface decodes the global status word and the per-channel codes. Channel 0's pending bit is in bit 0, channel 1's is in bit 1, and all other bits read zero.

Top module: `uart_irq_prio`

## Requirements
- R1: After reset, with no source pending, every channel code is 000, every pending bit is 0, the status word is 0 and `irq` is 0.
- R2: Code 001 is reported while `rx_lvl_hit` is high, or while the line-status latch is set. That latch is set when any of the channel's four `line_err` flags is high, and it is cleared by `lsr_rd`.
- R3: A `rx_tmo` strobe latches code 010. The latch is cleared only while `rx_empty` is high. Register reads leave it set.
- R4: A `tx_empty` strobe latches code 011, and `isr_rd` clears it.
- R5: Code 100 is reported for three latches. The modem-delta latch is cleared by `msr_rd`. The flow-character latch is cleared by `isr_rd`. The special-character latch is cleared by either `isr_rd` or `rx_char`.
- R6: On channel 0 only, `io_chg` latches code 110 (cleared by `io_lvl_rd`) and `tick_exp` latches code 111 (cleared by `tmr_ctl_rd`). Channel 1 never reports 110 or 111, and no channel ever reports 101.
- R7: When several sources are pending, the code shows the smallest non-zero code among them. The other sources stay latched until their own clear event arrives.
- R8: If a set event and a clear event for the same latch arrive in the same cycle, the latch ends up set.
- R9: `glob_stat` bit c equals channel c's pending bit, the remaining bits are zero, and `irq` is the OR of the pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_lvl_hit | input | 2 | Per channel: receive FIFO fill is at or above its trigger (level) |
| rx_empty | input | 2 | Per channel: receive FIFO is empty (level) |
| line_err | input | 8 | Four line-status error flags per channel; channel c uses bits 4c+3..4c |
| rx_tmo | input | 2 | Per channel: receive timeout strobe |
| tx_empty | input | 2 | Per channel: transmit holding or shift register empty strobe |
| modem_delta | input | 2 | Per channel: modem or handshake line change strobe |
| flow_chr | input | 2 | Per channel: flow-control character detected strobe |
| spec_chr | input | 2 | Per channel: special character detected strobe |
| rx_char | input | 2 | Per channel: a character was received |
| lsr_rd | input | 2 | Per channel: line status register read |
| isr_rd | input | 2 | Per channel: interrupt status register read |
| msr_rd | input | 2 | Per channel: modem status register read |
| io_chg | input | 1 | Multipurpose I/O change strobe (channel 0) |
| tick_exp | input | 1 | Timer expiry strobe (channel 0) |
| io_lvl_rd | input | 1 | I/O level register read |
| tmr_ctl_rd | input | 1 | Timer control register read |
| src_code | output | 6 | 3-bit source code per channel; channel c uses bits 3c+2..3c |
| chan_pend | output | 2 | Per channel: any source pending |
| glob_stat | output | 8 | Global interrupt status word |
| irq | output | 1 | Interrupt line, active high |

## Verification
The assertions check four things on every cycle. Each latch follows its set-over-clear rule and holds when neither event is present. The reserved code and the channel-0-only codes never appear where they are forbidden. The receive level and the line-status latch force code 001. The interrupt line agrees with the status word. Only the bench scenarios show that each source is tied to the correct clear strobe, for example that a timeout survives a status read and leaves only on an empty FIFO. They also show that hidden lower-precedence sources reappear in the right order once the higher ones are cleared. A cycle-level model checks these against the outputs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [2:0] {
    CODE_NONE = 3'd0,
    CODE_RX   = 3'd1,
    CODE_TMO  = 3'd2,
    CODE_TX   = 3'd3,
    CODE_MDM  = 3'd4,
    CODE_RSV  = 3'd5,
    CODE_IO   = 3'd6,
    CODE_TMR  = 3'd7
  } irq_code_e;

  // smallest set index wins; request bit k stands for code k
  function automatic logic [2:0] pick_code(input logic [7:1] req);
    logic [2:0] r;
    r = 3'd0;
    for (int k = 7; k >= 1; k--) begin
      if (req[k]) r = 3'(k);
    end
    return r;
  endfunction

endpackage

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= set | (q & ~clr);
  end

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(q));
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);

endmodule

// File: rtl/irq_chan.sv
module irq_chan
  import uart_irq_pkg::*;
#(
  parameter bit HAS_IO = 1'b1,
  parameter int ERR_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_lvl_hit,
  input  logic             rx_empty,
  input  logic [ERR_W-1:0] line_err,
  input  logic             rx_tmo,
  input  logic             tx_empty,
  input  logic             modem_delta,
  input  logic             flow_chr,
  input  logic             spec_chr,
  input  logic             rx_char,
  input  logic             lsr_rd,
  input  logic             isr_rd,
  input  logic             msr_rd,
  input  logic             io_chg,
  input  logic             tick_exp,
  input  logic             io_lvl_rd,
  input  logic             tmr_ctl_rd,
  output logic [2:0]       code,
  output logic             pend
);

  logic ls_q, tmo_q, tx_q, md_q, fc_q, sc_q, io_q, tm_q;
  logic line_any;
  logic [7:1] req;

  assign line_any = |line_err;

  irq_latch u_ls  (.clk(clk), .rst_n(rst_n), .set(line_any),    .clr(lsr_rd),            .q(ls_q));
  irq_latch u_tmo (.clk(clk), .rst_n(rst_n), .set(rx_tmo),      .clr(rx_empty),          .q(tmo_q));
  irq_latch u_tx  (.clk(clk), .rst_n(rst_n), .set(tx_empty),    .clr(isr_rd),            .q(tx_q));
  irq_latch u_md  (.clk(clk), .rst_n(rst_n), .set(modem_delta), .clr(msr_rd),            .q(md_q));
  irq_latch u_fc  (.clk(clk), .rst_n(rst_n), .set(flow_chr),    .clr(isr_rd),            .q(fc_q));
  irq_latch u_sc  (.clk(clk), .rst_n(rst_n), .set(spec_chr),    .clr(isr_rd | rx_char),  .q(sc_q));
  irq_latch u_io  (.clk(clk), .rst_n(rst_n), .set(io_chg & HAS_IO),   .clr(io_lvl_rd),   .q(io_q));
  irq_latch u_tm  (.clk(clk), .rst_n(rst_n), .set(tick_exp & HAS_IO), .clr(tmr_ctl_rd),  .q(tm_q));

  always_comb begin
    req          = '0;
    req[CODE_RX]  = rx_lvl_hit | ls_q;
    req[CODE_TMO] = tmo_q;
    req[CODE_TX]  = tx_q;
    req[CODE_MDM] = md_q | fc_q | sc_q;
    req[CODE_IO]  = io_q;
    req[CODE_TMR] = tm_q;
  end

  assign code = pick_code(req);
  assign pend = (code != CODE_NONE);

  a_r6_no_rsv: assert property (@(posedge clk) disable iff (!rst_n)
    code != CODE_RSV);
  a_r2_rx_first: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_lvl_hit || ls_q) |-> code == CODE_RX);
  a_r3_tmo_seen: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_q && !rx_lvl_hit && !ls_q) |-> code == CODE_TMO);

  generate
    if (!HAS_IO) begin : g_no_io
      a_r6_io_only: assert property (@(posedge clk) disable iff (!rst_n)
        code != CODE_IO && code != CODE_TMR);
    end
  endgenerate

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio #(
  parameter int NUM_CH = 2,
  parameter int ERR_W  = 4,
  parameter int STAT_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       rx_lvl_hit,
  input  logic [NUM_CH-1:0]       rx_empty,
  input  logic [NUM_CH*ERR_W-1:0] line_err,
  input  logic [NUM_CH-1:0]       rx_tmo,
  input  logic [NUM_CH-1:0]       tx_empty,
  input  logic [NUM_CH-1:0]       modem_delta,
  input  logic [NUM_CH-1:0]       flow_chr,
  input  logic [NUM_CH-1:0]       spec_chr,
  input  logic [NUM_CH-1:0]       rx_char,
  input  logic [NUM_CH-1:0]       lsr_rd,
  input  logic [NUM_CH-1:0]       isr_rd,
  input  logic [NUM_CH-1:0]       msr_rd,
  input  logic                    io_chg,
  input  logic                    tick_exp,
  input  logic                    io_lvl_rd,
  input  logic                    tmr_ctl_rd,
  output logic [NUM_CH*3-1:0]     src_code,
  output logic [NUM_CH-1:0]       chan_pend,
  output logic [STAT_W-1:0]       glob_stat,
  output logic                    irq
);

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      localparam bit IO_HERE = (c == 0);
      irq_chan #(.HAS_IO(IO_HERE), .ERR_W(ERR_W)) u_chan (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_lvl_hit (rx_lvl_hit[c]),
        .rx_empty   (rx_empty[c]),
        .line_err   (line_err[c*ERR_W +: ERR_W]),
        .rx_tmo     (rx_tmo[c]),
        .tx_empty   (tx_empty[c]),
        .modem_delta(modem_delta[c]),
        .flow_chr   (flow_chr[c]),
        .spec_chr   (spec_chr[c]),
        .rx_char    (rx_char[c]),
        .lsr_rd     (lsr_rd[c]),
        .isr_rd     (isr_rd[c]),
        .msr_rd     (msr_rd[c]),
        .io_chg     (io_chg),
        .tick_exp   (tick_exp),
        .io_lvl_rd  (io_lvl_rd),
        .tmr_ctl_rd (tmr_ctl_rd),
        .code       (src_code[c*3 +: 3]),
        .pend       (chan_pend[c])
      );
    end
  endgenerate

  always_comb begin
    glob_stat = '0;
    glob_stat[NUM_CH-1:0] = chan_pend;
  end

  assign irq = |chan_pend;

  a_r9_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (glob_stat != '0));
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_pend == '0) |-> (src_code == '0));

endmodule

// File: tb/sim_uart_irq_prio.sv
module sim_uart_irq_prio;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] rx_lvl_hit, rx_empty, rx_tmo, tx_empty, modem_delta;
  logic [1:0] flow_chr, spec_chr, rx_char, lsr_rd, isr_rd, msr_rd;
  logic [7:0] line_err;
  logic io_chg, tick_exp, io_lvl_rd, tmr_ctl_rd;
  logic [5:0] src_code;
  logic [1:0] chan_pend;
  logic [7:0] glob_stat;
  logic irq;

  int total = 0;
  int bad = 0;

  // behavioural model: one flag per source and channel
  bit m_ls[2], m_tmo[2], m_tx[2], m_md[2], m_fc[2], m_sc[2];
  bit m_io, m_tm;

  always #(CLK_P/2) clk = ~clk;

  uart_irq_prio u0 (
    .clk(clk), .rst_n(rst_n), .rx_lvl_hit(rx_lvl_hit), .rx_empty(rx_empty),
    .line_err(line_err), .rx_tmo(rx_tmo), .tx_empty(tx_empty),
    .modem_delta(modem_delta), .flow_chr(flow_chr), .spec_chr(spec_chr),
    .rx_char(rx_char), .lsr_rd(lsr_rd), .isr_rd(isr_rd), .msr_rd(msr_rd),
    .io_chg(io_chg), .tick_exp(tick_exp), .io_lvl_rd(io_lvl_rd),
    .tmr_ctl_rd(tmr_ctl_rd), .src_code(src_code), .chan_pend(chan_pend),
    .glob_stat(glob_stat), .irq(irq)
  );

  task automatic idle_inputs();
    rx_lvl_hit = 0; rx_empty = 0; rx_tmo = 0; tx_empty = 0; modem_delta = 0;
    flow_chr = 0; spec_chr = 0; rx_char = 0; lsr_rd = 0; isr_rd = 0;
    msr_rd = 0; line_err = 0; io_chg = 0; tick_exp = 0; io_lvl_rd = 0;
    tmr_ctl_rd = 0;
  endtask

  function automatic int want_code(int c);
    int cand[$];
    if (rx_lvl_hit[c] || m_ls[c]) cand.push_back(1);
    if (m_tmo[c]) cand.push_back(2);
    if (m_tx[c]) cand.push_back(3);
    if (m_md[c] || m_fc[c] || m_sc[c]) cand.push_back(4);
    if (c == 0 && m_io) cand.push_back(6);
    if (c == 0 && m_tm) cand.push_back(7);
    if (cand.size() == 0) return 0;
    return cand[0];
  endfunction

  task automatic chk(string tag, int act, int exp, string what);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    int any;
    int w;
    any = 0;
    for (int c = 0; c < 2; c++) begin
      w = want_code(c);
      chk(tag, int'(src_code[c*3 +: 3]), w, $sformatf("code ch%0d", c));
      chk(tag, int'(chan_pend[c]), (w != 0) ? 1 : 0, $sformatf("pend ch%0d", c));
      if (w != 0) any = any + (1 << c);
    end
    chk("R9", int'(glob_stat), any, "glob_stat");
    chk("R9", int'(irq), (any != 0) ? 1 : 0, "irq");
  endtask

  task automatic model_clock();
    for (int c = 0; c < 2; c++) begin
      m_ls[c]  = (line_err[c*4 +: 4] != 0) || (m_ls[c] && !lsr_rd[c]);
      m_tmo[c] = rx_tmo[c] || (m_tmo[c] && !rx_empty[c]);
      m_tx[c]  = tx_empty[c] || (m_tx[c] && !isr_rd[c]);
      m_md[c]  = modem_delta[c] || (m_md[c] && !msr_rd[c]);
      m_fc[c]  = flow_chr[c] || (m_fc[c] && !isr_rd[c]);
      m_sc[c]  = spec_chr[c] || (m_sc[c] && !(isr_rd[c] || rx_char[c]));
    end
    m_io = io_chg || (m_io && !io_lvl_rd);
    m_tm = tick_exp || (m_tm && !tmr_ctl_rd);
  endtask

  // inputs set by caller are applied for one cycle
  task automatic step(string tag);
    @(negedge clk);
    #1 compare(tag);
    @(posedge clk);
    model_clock();
    #1 idle_inputs();
  endtask

  initial begin
    #(CLK_P * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle_inputs();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step("R1");
    step("R1");

    // R2 level and line latch
    rx_lvl_hit = 2'b01; step("R2");
    step("R2");
    line_err = 8'b0100_0000; step("R2");
    step("R2");
    isr_rd = 2'b10; step("R2");
    lsr_rd = 2'b01; step("R2");
    lsr_rd = 2'b10; step("R2");
    step("R2");

    // R3 timeout cleared only by empty fifo
    rx_tmo = 2'b01; step("R3");
    isr_rd = 2'b01; lsr_rd = 2'b01; msr_rd = 2'b01; step("R3");
    rx_empty = 2'b01; step("R3");
    step("R3");

    // R4 transmit empty
    tx_empty = 2'b10; step("R4");
    msr_rd = 2'b10; step("R4");
    isr_rd = 2'b10; step("R4");
    step("R4");

    // R5 code 100 sources
    modem_delta = 2'b01; step("R5");
    isr_rd = 2'b01; step("R5");
    msr_rd = 2'b01; step("R5");
    flow_chr = 2'b10; step("R5");
    msr_rd = 2'b10; step("R5");
    isr_rd = 2'b10; step("R5");
    spec_chr = 2'b11; step("R5");
    rx_char = 2'b01; step("R5");
    isr_rd = 2'b10; step("R5");
    step("R5");

    // R6 channel-0-only sources
    io_chg = 1; step("R6");
    tmr_ctl_rd = 1; step("R6");
    io_lvl_rd = 1; step("R6");
    tick_exp = 1; step("R6");
    io_lvl_rd = 1; step("R6");
    tmr_ctl_rd = 1; step("R6");
    step("R6");

    // R7 precedence and retention
    tx_empty = 2'b01; rx_tmo = 2'b01; modem_delta = 2'b01; tick_exp = 1; io_chg = 1;
    step("R7");
    step("R7");
    rx_empty = 2'b01; step("R7");
    isr_rd = 2'b01; step("R7");
    msr_rd = 2'b01; step("R7");
    io_lvl_rd = 1; step("R7");
    tmr_ctl_rd = 1; step("R7");
    step("R7");

    // R8 set beats clear
    tx_empty = 2'b11; isr_rd = 2'b11; step("R8");
    step("R8");
    rx_tmo = 2'b10; rx_empty = 2'b10; step("R8");
    step("R8");
    tick_exp = 1; tmr_ctl_rd = 1; step("R8");
    step("R8");
    isr_rd = 2'b11; rx_empty = 2'b10; tmr_ctl_rd = 1; step("R8");
    step("R8");

    // R9 both channels at once
    line_err = 8'b0001_0010; step("R9");
    lsr_rd = 2'b01; step("R9");
    lsr_rd = 2'b10; step("R9");
    step("R1");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule